// File: doc/BRIEF.md
# LSB-Justified Serial Audio Channel Transceiver

This block is a master-side serial audio port. It drives a bit clock and a channel-select line and sends one data line out. It samples a second data line in. Each channel occupies a 32-bit slot, and slots alternate between the left and right channel. The audio word sits at the tail of its slot, with zero fill in front of it. The word is either 16 bits wide, or 24 bits wide and carried in two half-word transfers.

User logic exchanges 16-bit half-words through a write port and a read port. Two handshake flags pace these transfers:
- `tx_empty` reports that the transmit holding register may be written.
- `rx_full` reports that a received half-word is waiting to be read.

Both flags change only around the meaningful part of a slot, so the zero fill gives the user time to respond. Sticky flags report a missed write (underrun) and a missed read (overrun). A side bit tells which channel the waiting received half-word came from.

A slot sequencer walks through the following states:
- `PH_IDLE`: stopped.
- `PH_PAD`: zero fill.
- `PH_UPPER`: the 8 upper data bits, used in 24-bit mode only.
- `PH_LOWER`: the final 16 data bits.

Its transitions are:
- start: `PH_IDLE`→`PH_PAD` when enabled.
- upper-load: `PH_PAD`→`PH_UPPER` at slot bit 8 in 24-bit mode.
- lower-load: `PH_PAD`/`PH_UPPER`→`PH_LOWER` at slot bit 16.
- wrap: `PH_LOWER`→`PH_PAD` at the start of the next slot.
- stop: any state→`PH_IDLE` when disabled.

Top module: `lsbj_audio_port`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `underrun`=0, `overrun`=0, and `ck_out`, `ws_out` and `sd_out` are all 0.
- R2: While enabled, `ck_out` toggles every CK_HALF clock cycles, starting low, with its first rise CK_HALF cycles after the first enabled edge. While disabled it is held low.
- R3: Slots are 32 bits long and alternate, starting with left. `ws_out` is 0 for a left slot and 1 for a right slot. It changes on the falling CK edge that starts the last bit of the preceding slot.
- R4: In 16-bit mode (`wide_mode`=0) a slot carries 16 zeros and then the written half-word, MSB first. One write serves one slot.
- R5: In 24-bit mode (`wide_mode`=1) a slot carries 8 zeros and then a 24-bit word, MSB first. The first write of the slot supplies word bits 23:16 in its bits 7:0, and the second write supplies bits 15:0.
- R6: `sd_out` changes only on falling CK edges. `sd_in` is sampled on rising edges, so a loopback returns each 16-bit word as one read.
- R7: In 24-bit mode each slot yields two reads: first {8'h00, word[23:16]}, then word[15:0].
- R8: An accepted write clears `tx_empty`. `tx_empty` sets again when the half-word moves onto the line, at slot bit 16, and also at bit 8 in 24-bit mode. A write while `tx_empty`=0 is ignored.
- R9: `rx_full` sets on the rising CK edge that samples the last bit of a meaningful half-word, which is slot bit 31, and also bit 15 in 24-bit mode. A read clears it.
- R10: If `tx_empty` is still 1 when a half-word must be loaded, zeros are sent in its place and `underrun` sets. An accepted write clears `underrun`.
- R11: If `rx_full` is still 1 when a half-word completes, `overrun` sets and the new half-word is discarded, so `rd_data` keeps the old one. A read clears `overrun`.
- R12: `rx_side` gives the channel (0 left, 1 right) of the slot the waiting received half-word came from.
- R13: `wide_mode` is latched when the port starts and is ignored while it runs. Disabling returns `ck_out`, `ws_out` and `sd_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the port while high |
| wide_mode | input | 1 | 0: 16-bit words, 1: 24-bit words (latched at start) |
| wr_en | input | 1 | Write strobe for the transmit half-word |
| wr_data | input | 16 | Transmit half-word |
| tx_empty | output | 1 | Transmit holding register may be written |
| rd_en | input | 1 | Read strobe for the received half-word |
| rd_data | output | 16 | Received half-word |
| rx_full | output | 1 | Received half-word waiting |
| underrun | output | 1 | Sticky: a load found no data |
| overrun | output | 1 | Sticky: a received half-word was dropped |
| rx_side | output | 1 | Channel of the waiting received half-word |
| ck_out | output | 1 | Bit clock, idles low |
| ws_out | output | 1 | Channel select |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |

## Verification
Errors in the sequencer's bit index or phase show up on `sd_out` within one CK period. That is because the bench predicts every clock level, channel-select level and data bit from a plain count of cycles since start. A wrong channel register shows up on `ws_out` at the next slot boundary. A wrong load or capture point moves the first `tx_empty` or `rx_full` rise away from its predicted cycle. Flag and discard errors show up in the values read back after a deliberate missed write and a missed read.

// File: rtl/lsbj_pkg.sv
package lsbj_pkg;

    // Where the sequencer is inside the current slot
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PAD   = 2'd1,
        PH_UPPER = 2'd2,
        PH_LOWER = 2'd3
    } slot_phase_e;

endpackage

// File: rtl/lsbj_bitclk.sv
module lsbj_bitclk #(
    parameter int CK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ck,
    output logic rise_tk,
    output logic fall_tk
);
    localparam int CW = (CK_HALF > 1) ? $clog2(CK_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CK_HALF - 1);

    logic [CW-1:0] cnt;
    logic          edge_due;

    always_comb begin
        edge_due = run && (cnt == CNT_LAST);
        rise_tk  = edge_due && !ck;
        fall_tk  = edge_due && ck;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            ck  <= 1'b0;
        end else if (edge_due) begin
            cnt <= '0;
            ck  <= ~ck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lsbj_slot_fsm.sv
module lsbj_slot_fsm
    import lsbj_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int HALF_W = 16,
    parameter int WIDE_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wide_in,
    input  logic rise_tk,
    input  logic fall_tk,
    output logic slot_ch,
    output logic ws,
    output logic ld_upper,
    output logic ld_lower,
    output logic drv_shift,
    output logic drv_pad,
    output logic cap_upper,
    output logic cap_lower
);
    localparam int IDX_W = $clog2(SLOT_W);
    localparam logic [IDX_W-1:0] IX_UPPER     = IDX_W'(SLOT_W - WIDE_W);
    localparam logic [IDX_W-1:0] IX_LOWER     = IDX_W'(SLOT_W - HALF_W);
    localparam logic [IDX_W-1:0] IX_UPPER_END = IDX_W'(SLOT_W - HALF_W - 1);
    localparam logic [IDX_W-1:0] IX_LAST      = IDX_W'(SLOT_W - 1);

    slot_phase_e      phase, nxt_phase;
    logic [IDX_W-1:0] idx, nxt_idx;
    logic             wide_q;
    logic             running;
    logic             wrap_next;

    // Event decode for the coming CK edge
    always_comb begin
        running   = (phase != PH_IDLE);
        nxt_idx   = (idx == IX_LAST) ? '0 : idx + 1'b1;
        wrap_next = fall_tk && running && (idx == IX_LAST);
        ld_upper  = fall_tk && running && wide_q && (nxt_idx == IX_UPPER);
        ld_lower  = fall_tk && running && (nxt_idx == IX_LOWER);
        drv_shift = fall_tk && ((phase == PH_UPPER) || (phase == PH_LOWER))
                    && !ld_lower && !wrap_next;
        drv_pad   = fall_tk && running && !ld_upper && !ld_lower && !drv_shift;
        cap_upper = rise_tk && (phase == PH_UPPER) && (idx == IX_UPPER_END);
        cap_lower = rise_tk && (phase == PH_LOWER) && (idx == IX_LAST);
    end

    always_comb begin
        nxt_phase = phase;
        unique case (phase)
            PH_IDLE:  if (run) nxt_phase = PH_PAD;
            PH_PAD: begin
                if (!run)          nxt_phase = PH_IDLE;
                else if (ld_upper) nxt_phase = PH_UPPER;
                else if (ld_lower) nxt_phase = PH_LOWER;
            end
            PH_UPPER: begin
                if (!run)          nxt_phase = PH_IDLE;
                else if (ld_lower) nxt_phase = PH_LOWER;
            end
            PH_LOWER: begin
                if (!run)           nxt_phase = PH_IDLE;
                else if (wrap_next) nxt_phase = PH_PAD;
            end
            default:  nxt_phase = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt_phase;
    end

    // Slot position, channel and channel-select outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            slot_ch <= 1'b0;
            ws      <= 1'b0;
            wide_q  <= 1'b0;
        end else if (phase == PH_IDLE || nxt_phase == PH_IDLE) begin
            idx     <= '0;
            slot_ch <= 1'b0;
            ws      <= 1'b0;
            wide_q  <= wide_in;
        end else if (fall_tk) begin
            idx <= nxt_idx;
            if (wrap_next)            slot_ch <= ~slot_ch;
            if (nxt_idx == IX_LAST)   ws      <= ~slot_ch;
        end
    end
endmodule

// File: rtl/lsbj_tx_path.sv
module lsbj_tx_path #(
    parameter int HALF_W = 16,
    parameter int WIDE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_upper,
    input  logic              ld_lower,
    input  logic              drv_shift,
    input  logic              drv_pad,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              underrun,
    output logic              sd
);
    localparam int UP_W = WIDE_W - HALF_W;

    logic [HALF_W-1:0] hold;
    logic [HALF_W-1:0] sh;
    logic [HALF_W-1:0] ld_word;
    logic              ld_any;

    always_comb begin
        ld_any = ld_upper || ld_lower;
        if (tx_empty)      ld_word = '0;
        else if (ld_upper) ld_word = {hold[UP_W-1:0], {(HALF_W-UP_W){1'b0}}};
        else               ld_word = hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            sh       <= '0;
            tx_empty <= 1'b1;
            underrun <= 1'b0;
            sd       <= 1'b0;
        end else begin
            if (wr_en && tx_empty) begin
                hold     <= wr_data;
                tx_empty <= 1'b0;
                underrun <= 1'b0;
            end
            if (!run) begin
                sd <= 1'b0;
            end else if (ld_any) begin
                if (!tx_empty) tx_empty <= 1'b1;
                else           underrun <= 1'b1;
                sd <= ld_word[HALF_W-1];
                sh <= {ld_word[HALF_W-2:0], 1'b0};
            end else if (drv_shift) begin
                sd <= sh[HALF_W-1];
                sh <= {sh[HALF_W-2:0], 1'b0};
            end else if (drv_pad) begin
                sd <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lsbj_rx_path.sv
module lsbj_rx_path #(
    parameter int HALF_W = 16,
    parameter int WIDE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_tk,
    input  logic              sd_in,
    input  logic              cap_upper,
    input  logic              cap_lower,
    input  logic              slot_ch,
    input  logic              rd_en,
    output logic [HALF_W-1:0] rd_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              rx_side
);
    localparam int UP_W = WIDE_W - HALF_W;

    logic [HALF_W-1:0] rsh;
    logic [HALF_W-1:0] cap_word;

    always_comb begin
        if (cap_upper) cap_word = {{(HALF_W-UP_W){1'b0}}, rsh[UP_W-2:0], sd_in};
        else           cap_word = {rsh[HALF_W-2:0], sd_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsh     <= '0;
            rd_data <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
            rx_side <= 1'b0;
        end else begin
            if (rise_tk) rsh <= {rsh[HALF_W-2:0], sd_in};
            if (rd_en && rx_full) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
            if (cap_upper || cap_lower) begin
                if (rx_full) begin
                    overrun <= 1'b1;
                end else begin
                    rd_data <= cap_word;
                    rx_full <= 1'b1;
                    rx_side <= slot_ch;
                end
            end
        end
    end
endmodule

// File: rtl/lsbj_audio_port.sv
module lsbj_audio_port #(
    parameter int CK_HALF = 2,
    parameter int SLOT_W  = 32,
    parameter int HALF_W  = 16,
    parameter int WIDE_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wide_mode,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_data,
    output logic              tx_empty,
    input  logic              rd_en,
    output logic [HALF_W-1:0] rd_data,
    output logic              rx_full,
    output logic              underrun,
    output logic              overrun,
    output logic              rx_side,
    output logic              ck_out,
    output logic              ws_out,
    output logic              sd_out,
    input  logic              sd_in
);
    logic rise_tk, fall_tk;
    logic slot_ch;
    logic ld_upper, ld_lower, drv_shift, drv_pad, cap_upper, cap_lower;

    lsbj_bitclk #(.CK_HALF(CK_HALF)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (enable),
        .ck      (ck_out),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    lsbj_slot_fsm #(.SLOT_W(SLOT_W), .HALF_W(HALF_W), .WIDE_W(WIDE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .wide_in   (wide_mode),
        .rise_tk   (rise_tk),
        .fall_tk   (fall_tk),
        .slot_ch   (slot_ch),
        .ws        (ws_out),
        .ld_upper  (ld_upper),
        .ld_lower  (ld_lower),
        .drv_shift (drv_shift),
        .drv_pad   (drv_pad),
        .cap_upper (cap_upper),
        .cap_lower (cap_lower)
    );

    lsbj_tx_path #(.HALF_W(HALF_W), .WIDE_W(WIDE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .ld_upper  (ld_upper),
        .ld_lower  (ld_lower),
        .drv_shift (drv_shift),
        .drv_pad   (drv_pad),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_empty  (tx_empty),
        .underrun  (underrun),
        .sd        (sd_out)
    );

    lsbj_rx_path #(.HALF_W(HALF_W), .WIDE_W(WIDE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_tk   (rise_tk),
        .sd_in     (sd_in),
        .cap_upper (cap_upper),
        .cap_lower (cap_lower),
        .slot_ch   (slot_ch),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rx_full   (rx_full),
        .overrun   (overrun),
        .rx_side   (rx_side)
    );
endmodule

// File: rtl/lsbj_audio_port_chk.sv
module lsbj_audio_port_chk #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              wr_en,
    input logic              rd_en,
    input logic              tx_empty,
    input logic              rx_full,
    input logic [HALF_W-1:0] rd_data,
    input logic              underrun,
    input logic              ck_out,
    input logic              ws_out,
    input logic              sd_out
);
    a_r2_ck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ck_out);

    a_r6_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !$stable(sd_out)) |-> $fell(ck_out));

    a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !$stable(ws_out)) |-> $fell(ck_out));

    a_r8_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && wr_en) |=> !tx_empty);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rd_en) |=> !rx_full);

    a_r11_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_en) |=> $stable(rd_data));

    a_r10_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(tx_empty));
endmodule

bind lsbj_audio_port lsbj_audio_port_chk #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .rd_data  (rd_data),
    .underrun (underrun),
    .ck_out   (ck_out),
    .ws_out   (ws_out),
    .sd_out   (sd_out)
);

// File: tb/lsbj_audio_port_test.sv
`timescale 1ns/1ps
module lsbj_audio_port_test;
    localparam int K    = 2;
    localparam int SLOT = 32;
    localparam int BITP = 2 * K;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wide_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        tx_empty, rx_full, underrun, overrun, rx_side;
    logic [15:0] rd_data;
    logic        ck_out, ws_out, sd_out, sd_loop;

    assign sd_loop = sd_out;

    lsbj_audio_port #(.CK_HALF(K)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wide_mode(wide_mode),
        .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
        .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full),
        .underrun(underrun), .overrun(overrun), .rx_side(rx_side),
        .ck_out(ck_out), .ws_out(ws_out), .sd_out(sd_out), .sd_in(sd_loop)
    );

    always #2.5 clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    int          ncyc = -1;
    bit          done = 0;
    bit          wide_run = 0;
    logic [31:0] slots [16];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Count of clock edges since the port was started
    always @(posedge clk) ncyc <= enable ? ncyc + 1 : -1;

    // Per-clock reference model for the line signals (R2, R3, R4, R5, R13)
    always @(negedge clk) begin
        if (ncyc >= 0) begin
            int b, s, ix;
            logic e_ck, e_ws, e_sd;
            b    = (ncyc + 1) / BITP;
            s    = b / SLOT;
            ix   = b % SLOT;
            e_ck = ((ncyc + 1) / K) % 2;
            e_ws = ((b + 1) / SLOT) % 2;
            e_sd = (s < 16) ? slots[s][SLOT-1-ix] : 1'b0;
            check(ck_out == e_ck, "R2 ck", 32'(ck_out), 32'(e_ck));
            check(ws_out == e_ws, "R3 ws", 32'(ws_out), 32'(e_ws));
            check(sd_out == e_sd, wide_run ? "R5 sd" : "R4/R13 sd", 32'(sd_out), 32'(e_sd));
        end
    end

    task automatic do_reset();
        enable = 0; wr_en = 0; rd_en = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Waits for tx_empty, writes, then tries a write that must be ignored (R8)
    task automatic write_hw(input logic [15:0] v);
        do @(negedge clk); while (!tx_empty);
        wr_en = 1; wr_data = v;
        @(negedge clk);
        wr_data = 16'hFFFF;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic read_hw(input logic [15:0] ed, input logic es, input string req);
        while (!rx_full) @(negedge clk);
        check(rd_data == ed, req, 32'(rd_data), 32'(ed));
        check(rx_side == es, "R12 side", 32'(rx_side), 32'(es));
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        @(negedge clk);
    endtask

    task automatic finish_run(input logic [15:0] kept, input logic kept_side, input string req);
        while (ncyc < 6 * SLOT * BITP) @(negedge clk);
        check(underrun == 1'b1, "R10 underrun set", 32'(underrun), 32'd1);
        check(overrun == 1'b1, "R11 overrun set", 32'(overrun), 32'd1);
        enable = 0;
        repeat (2) @(negedge clk);
        check({ck_out, ws_out, sd_out} == 3'b000, "R13 idle lines", 32'({ck_out, ws_out, sd_out}), 32'd0);
        check(rx_full == 1'b1, "R9 full held", 32'(rx_full), 32'd1);
        check(rd_data == kept, req, 32'(rd_data), 32'(kept));
        check(rx_side == kept_side, "R12 side kept", 32'(rx_side), 32'(kept_side));
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        @(negedge clk);
        check(overrun == 1'b0, "R11 overrun cleared by read", 32'(overrun), 32'd0);
        check(rx_full == 1'b0, "R9 full cleared by read", 32'(rx_full), 32'd0);
        write_hw(16'h1111);
        check(underrun == 1'b0, "R10 underrun cleared by write", 32'(underrun), 32'd0);
        check(tx_empty == 1'b0, "R8 write clears empty", 32'(tx_empty), 32'd0);
    endtask

    initial begin
        int t_first;
        for (int i = 0; i < 16; i++) slots[i] = '0;
        do_reset();
        // R1: reset state
        check(tx_empty == 1'b1, "R1 tx_empty", 32'(tx_empty), 32'd1);
        check(rx_full == 1'b0, "R1 rx_full", 32'(rx_full), 32'd0);
        check({underrun, overrun} == 2'b00, "R1 flags", 32'({underrun, overrun}), 32'd0);
        check({ck_out, ws_out, sd_out} == 3'b000, "R1 lines", 32'({ck_out, ws_out, sd_out}), 32'd0);

        // ---- 16-bit run (R4, R6, R8, R9, R10, R11, R12, R13) ----
        wide_run = 0;
        slots[0] = 32'h0000_76A3; slots[1] = 32'h0000_76A3;
        slots[2] = 32'h0000_5A0F; slots[3] = 32'h0000_C381;
        wide_mode = 0;
        write_hw(16'h76A3);
        enable = 1;
        repeat (3) @(negedge clk);
        wide_mode = 1;                  // R13: ignored while running
        fork
            begin
                while (!tx_empty) @(negedge clk);
                check(ncyc == BITP * 16 - 1, "R8 first empty 16", 32'(ncyc), 32'(BITP * 16 - 1));
                write_hw(16'h76A3);
                write_hw(16'h5A0F);
                write_hw(16'hC381);
            end
            begin
                while (!rx_full) @(negedge clk);
                t_first = ncyc;
                check(t_first == BITP * 31 + K - 1, "R9 first full 16", 32'(t_first), 32'(BITP * 31 + K - 1));
                read_hw(16'h76A3, 1'b0, "R6 left 76A3");
                read_hw(16'h76A3, 1'b1, "R6 right 76A3");
                read_hw(16'h5A0F, 1'b0, "R6 word 5A0F");
            end
        join
        finish_run(16'hC381, 1'b1, "R11 kept C381");

        // ---- 24-bit run (R5, R7, R8, R9, R10, R11, R12) ----
        do_reset();
        for (int i = 0; i < 16; i++) slots[i] = '0;
        wide_run = 1;
        slots[0] = 32'h0034_78AE; slots[1] = 32'h0034_78AE;
        slots[2] = 32'h009A_5C31; slots[3] = 32'h0012_ABCD;
        wide_mode = 1;
        write_hw(16'h0034);
        enable = 1;
        fork
            begin
                while (!tx_empty) @(negedge clk);
                check(ncyc == BITP * 8 - 1, "R8 first empty 24", 32'(ncyc), 32'(BITP * 8 - 1));
                write_hw(16'h78AE);
                write_hw(16'hFF34);     // only bits 7:0 matter (R5)
                write_hw(16'h78AE);
                write_hw(16'h009A);
                write_hw(16'h5C31);
                write_hw(16'h0012);
                write_hw(16'hABCD);
            end
            begin
                while (!rx_full) @(negedge clk);
                t_first = ncyc;
                check(t_first == BITP * 15 + K - 1, "R9 first full 24", 32'(t_first), 32'(BITP * 15 + K - 1));
                read_hw(16'h0034, 1'b0, "R7 left upper");
                read_hw(16'h78AE, 1'b0, "R7 left lower");
                read_hw(16'h0034, 1'b1, "R7 right upper");
                read_hw(16'h78AE, 1'b1, "R7 right lower");
                read_hw(16'h009A, 1'b0, "R7 upper 9A");
                read_hw(16'h5C31, 1'b0, "R7 lower 5C31");
            end
        join
        finish_run(16'h0012, 1'b1, "R11 kept 0012");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule